// File: doc/BRIEF.md
# LZ77 Token Stream Decoder

This block turns a stream of compression tokens back into the original byte stream. A token is one of three things. It can be a literal byte. It can be a back-reference, which repeats bytes already produced. It can be an in-band control marker. Literal bytes go straight to the output, and each one is also stored in a circular history buffer. A back-reference names a distance back into that history and a repeat count. The block then copies bytes one at a time, and each copied byte is stored again. This means a reference that overlaps its own output, such as a run of one repeated byte, rebuilds correctly.

The history lives in an external memory with one read port and one write port. The block reaches it through four valid/ready channels: read request, read response, write request and write completion. Markers travel in the output stream beside the data. A reset marker also clears the decoder's history. A back-reference that reaches past the valid history is replaced by an error marker, and so is a marker with an unknown code. The output is one registered word with a valid/ready handshake, so a consumer can stall the decoder at any time.

Top module: `lz_token_decoder`

## Requirements
- R1: After the synchronous active-high reset `rst`, these hold: `out_valid`, `rd_req_valid` and `wr_req_valid` are low, `tok_ready` is high, and the history is empty, so any back-reference is rejected with mark code 9.
- R2: A token of kind 0 or kind 1 is a literal. It produces one output word with `out_is_mark`=0 and `out_data` equal to the symbol. The symbol is also written to the history at the current write pointer, and the pointer then advances by one.
- R3: A token of kind 2 is a back-reference with offset F and length L. It produces L+1 data words. Each byte is read from history address (write pointer − F − 1), emitted, and written back to the history. Overlapping copies therefore repeat bytes that the same copy produced.
- R4: A back-reference is rejected when F is not smaller than the number of valid history bytes. The block then emits exactly one word with `out_is_mark`=1 and mark 9, emits no data words, and leaves the history unchanged.
- R5: A token of kind 3 is a marker and produces one word with `out_is_mark`=1 and `out_data`=0. Codes 0 (none), 1 (end), 2 (reset) and every code of 8 or more pass through unchanged. Codes 3 to 7 become 8 (bad mark).
- R6: A marker with code 2 empties the history and returns the write pointer to address 0.
- R7: `tok_ready` stays low until every byte of the current back-reference has been emitted. Output words keep token order, so a following end marker comes after the last copied byte.
- R8: While `out_valid` is high and `out_ready` is low, the output word holds steady and is not lost.
- R9: No write request is raised while an earlier write still lacks its completion, and no read request is raised while a write is outstanding.
- R10: The write pointer wraps modulo the history depth (2^`HIST_AW`). The valid-history count saturates at that depth, so an offset of depth−1 is accepted and an offset equal to the depth is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Token accepted this cycle when valid |
| tok_kind | input | 2 | 0/1 literal, 2 back-reference, 3 marker |
| tok_sym | input | SYM_W | Literal symbol |
| tok_off | input | OFF_W | Back-reference distance minus one |
| tok_len | input | LEN_W | Back-reference byte count minus one |
| tok_mark | input | 4 | Marker code |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_is_mark | output | 1 | Word is a marker |
| out_data | output | SYM_W | Decoded byte (0 for markers) |
| out_mark | output | 4 | Marker code |
| rd_req_valid | output | 1 | History read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | HIST_AW | Read address |
| rd_resp_valid | input | 1 | Read data present |
| rd_resp_ready | output | 1 | Read data taken |
| rd_resp_data | input | SYM_W | Read data |
| wr_req_valid | output | 1 | History write request |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | HIST_AW | Write address |
| wr_req_data | output | SYM_W | Write data |
| wr_done_valid | input | 1 | Write completion |
| wr_done_ready | output | 1 | Completion taken |

## Verification
The bench builds the decoder with `HIST_AW`=4, which gives a 16-byte history, and leaves the 8-bit symbol and 16-bit offset and length at their defaults. With so small a history, a few literals are enough to make the write pointer wrap and the valid count saturate. The accept and reject boundary of R10 and the address arithmetic across the wrap can then be checked directly. The bench's memory model can hold back write completions by several cycles, and the output consumer stalls in a pseudo-random pattern. Together these stretch the ordering rules of R7, R8 and R9 over many cycles.

// File: rtl/lzd_pkg.sv
package lzd_pkg;

  localparam int MARK_W = 4;

  // token kinds
  localparam logic [1:0] TK_LIT_NEW = 2'd0;
  localparam logic [1:0] TK_LIT_REP = 2'd1;
  localparam logic [1:0] TK_COPY    = 2'd2;
  localparam logic [1:0] TK_MARK    = 2'd3;

  // marker codes
  localparam logic [MARK_W-1:0] MK_NONE      = 4'd0;
  localparam logic [MARK_W-1:0] MK_END       = 4'd1;
  localparam logic [MARK_W-1:0] MK_RESET     = 4'd2;
  localparam logic [MARK_W-1:0] MK_ERR_FLOOR = 4'd8;
  localparam logic [MARK_W-1:0] MK_BAD_MARK  = 4'd8;
  localparam logic [MARK_W-1:0] MK_BAD_PTR   = 4'd9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_RESP,
    ST_EMIT
  } dec_state_e;

  // known codes and error codes pass, reserved codes collapse to bad-mark
  function automatic logic [MARK_W-1:0] mark_fix(input logic [MARK_W-1:0] m);
    if (m >= MK_ERR_FLOOR || m <= MK_RESET) return m;
    return MK_BAD_MARK;
  endfunction

endpackage

// File: rtl/lzd_hist_track.sv
module lzd_hist_track #(
  parameter int AW    = 12,
  parameter int OFF_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          adv,
  input  logic [OFF_W-1:0] off,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_addr,
  output logic          off_ok
);
  localparam int DEPTH = 1 << AW;
  localparam int CNT_W = AW + 1;
  localparam int CMP_W = (OFF_W > CNT_W) ? OFF_W : CNT_W;

  logic [CNT_W-1:0] hist_cnt;
  logic [CMP_W-1:0] off_x, cnt_x;

  assign off_x   = CMP_W'(off);
  assign cnt_x   = CMP_W'(hist_cnt);
  assign off_ok  = off_x < cnt_x;
  assign rd_addr = wr_ptr - off[AW-1:0] - AW'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr   <= '0;
      hist_cnt <= '0;
    end else if (adv) begin
      wr_ptr <= wr_ptr + AW'(1);
      if (hist_cnt != CNT_W'(DEPTH)) hist_cnt <= hist_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lzd_ram_port.sv
module lzd_ram_port #(
  parameter int AW    = 12,
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want_wr,
  input  logic [AW-1:0]    wr_addr,
  input  logic [SYM_W-1:0] wr_data,
  input  logic             want_rd,
  input  logic [AW-1:0]    rd_addr,
  input  logic             want_resp,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic             resp_fire,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [AW-1:0]    rd_req_addr,
  input  logic             rd_resp_valid,
  output logic             rd_resp_ready,
  output logic             wr_req_valid,
  input  logic             wr_req_ready,
  output logic [AW-1:0]    wr_req_addr,
  output logic [SYM_W-1:0] wr_req_data,
  input  logic             wr_done_valid,
  output logic             wr_done_ready
);
  logic wr_pend;

  assign wr_req_valid  = want_wr && !wr_pend;
  assign wr_req_addr   = wr_addr;
  assign wr_req_data   = wr_data;
  assign rd_req_valid  = want_rd && !wr_pend;
  assign rd_req_addr   = rd_addr;
  assign rd_resp_ready = want_resp;
  assign wr_done_ready = 1'b1;

  assign wr_fire   = wr_req_valid && wr_req_ready;
  assign rd_fire   = rd_req_valid && rd_req_ready;
  assign resp_fire = rd_resp_valid && rd_resp_ready;

  always_ff @(posedge clk) begin
    if (rst)                wr_pend <= 1'b0;
    else if (wr_fire)       wr_pend <= 1'b1;
    else if (wr_done_valid) wr_pend <= 1'b0;
  end
endmodule

// File: rtl/lzd_out_stage.sv
module lzd_out_stage #(
  parameter int SYM_W  = 8,
  parameter int MARK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              ld_is_mark,
  input  logic [SYM_W-1:0]  ld_data,
  input  logic [MARK_W-1:0] ld_mark,
  output logic              can_load,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_mark,
  output logic [SYM_W-1:0]  out_data,
  output logic [MARK_W-1:0] out_mark
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_is_mark <= 1'b0;
      out_data    <= '0;
      out_mark    <= '0;
    end else if (ld && can_load) begin
      out_valid   <= 1'b1;
      out_is_mark <= ld_is_mark;
      out_data    <= ld_data;
      out_mark    <= ld_mark;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lz_token_decoder.sv
module lz_token_decoder
  import lzd_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int OFF_W   = 16,
  parameter int LEN_W   = 16,
  parameter int HIST_AW = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tok_valid,
  output logic               tok_ready,
  input  logic [1:0]         tok_kind,
  input  logic [SYM_W-1:0]   tok_sym,
  input  logic [OFF_W-1:0]   tok_off,
  input  logic [LEN_W-1:0]   tok_len,
  input  logic [MARK_W-1:0]  tok_mark,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_is_mark,
  output logic [SYM_W-1:0]   out_data,
  output logic [MARK_W-1:0]  out_mark,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [HIST_AW-1:0] rd_req_addr,
  input  logic               rd_resp_valid,
  output logic               rd_resp_ready,
  input  logic [SYM_W-1:0]   rd_resp_data,
  output logic               wr_req_valid,
  input  logic               wr_req_ready,
  output logic [HIST_AW-1:0] wr_req_addr,
  output logic [SYM_W-1:0]   wr_req_data,
  input  logic               wr_done_valid,
  output logic               wr_done_ready
);
  dec_state_e state;

  logic [SYM_W-1:0]  cur_byte;
  logic              cur_is_mark;
  logic [MARK_W-1:0] cur_mark;
  logic [LEN_W-1:0]  copy_left;
  logic [OFF_W-1:0]  copy_off;
  logic              in_copy;

  logic               tok_fire, hist_clear, hist_adv, off_ok;
  logic [OFF_W-1:0]   off_sel;
  logic [HIST_AW-1:0] wr_ptr, rd_addr;
  logic               wr_fire, rd_fire, resp_fire;
  logic               can_load, emit_ld;

  assign tok_ready  = (state == ST_IDLE);
  assign tok_fire   = tok_valid && tok_ready;
  assign hist_clear = tok_fire && (tok_kind == TK_MARK) && (tok_mark == MK_RESET);
  assign hist_adv   = wr_fire;
  assign off_sel    = (state == ST_IDLE) ? tok_off : copy_off;
  assign emit_ld    = (state == ST_EMIT) && can_load;

  lzd_hist_track #(.AW(HIST_AW), .OFF_W(OFF_W)) hist_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (hist_clear),
    .adv    (hist_adv),
    .off    (off_sel),
    .wr_ptr (wr_ptr),
    .rd_addr(rd_addr),
    .off_ok (off_ok)
  );

  lzd_ram_port #(.AW(HIST_AW), .SYM_W(SYM_W)) ram_i (
    .clk          (clk),
    .rst          (rst),
    .want_wr      (state == ST_WR),
    .wr_addr      (wr_ptr),
    .wr_data      (cur_byte),
    .want_rd      (state == ST_RD),
    .rd_addr      (rd_addr),
    .want_resp    (state == ST_RESP),
    .wr_fire      (wr_fire),
    .rd_fire      (rd_fire),
    .resp_fire    (resp_fire),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_resp_valid(rd_resp_valid),
    .rd_resp_ready(rd_resp_ready),
    .wr_req_valid (wr_req_valid),
    .wr_req_ready (wr_req_ready),
    .wr_req_addr  (wr_req_addr),
    .wr_req_data  (wr_req_data),
    .wr_done_valid(wr_done_valid),
    .wr_done_ready(wr_done_ready)
  );

  lzd_out_stage #(.SYM_W(SYM_W), .MARK_W(MARK_W)) out_i (
    .clk        (clk),
    .rst        (rst),
    .ld         (emit_ld),
    .ld_is_mark (cur_is_mark),
    .ld_data    (cur_byte),
    .ld_mark    (cur_mark),
    .can_load   (can_load),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_is_mark(out_is_mark),
    .out_data   (out_data),
    .out_mark   (out_mark)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cur_byte    <= '0;
      cur_is_mark <= 1'b0;
      cur_mark    <= MK_NONE;
      copy_left   <= '0;
      copy_off    <= '0;
      in_copy     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (tok_fire) begin
          cur_mark <= MK_NONE;
          if (tok_kind == TK_LIT_NEW || tok_kind == TK_LIT_REP) begin
            cur_byte    <= tok_sym;
            cur_is_mark <= 1'b0;
            in_copy     <= 1'b0;
            state       <= ST_WR;
          end else if (tok_kind == TK_COPY) begin
            if (off_ok) begin
              copy_off  <= tok_off;
              copy_left <= tok_len;
              in_copy   <= 1'b1;
              state     <= ST_RD;
            end else begin
              cur_byte    <= '0;
              cur_is_mark <= 1'b1;
              cur_mark    <= MK_BAD_PTR;
              in_copy     <= 1'b0;
              state       <= ST_EMIT;
            end
          end else begin
            cur_byte    <= '0;
            cur_is_mark <= 1'b1;
            cur_mark    <= mark_fix(tok_mark);
            in_copy     <= 1'b0;
            state       <= ST_EMIT;
          end
        end
        ST_RD:   if (rd_fire) state <= ST_RESP;
        ST_RESP: if (resp_fire) begin
          cur_byte    <= rd_resp_data;
          cur_is_mark <= 1'b0;
          state       <= ST_WR;
        end
        ST_WR:   if (wr_fire) state <= ST_EMIT;
        ST_EMIT: if (can_load) begin
          if (in_copy && copy_left != '0) begin
            copy_left <= copy_left - LEN_W'(1);
            state     <= ST_RD;
          end else begin
            in_copy <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lzd_checker.sv
module lzd_checker #(
  parameter int SYM_W  = 8,
  parameter int MARK_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tok_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_mark,
  input logic [SYM_W-1:0]  out_data,
  input logic [MARK_W-1:0] out_mark,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic              rd_resp_valid,
  input logic              rd_resp_ready,
  input logic              wr_req_valid,
  input logic              wr_req_ready,
  input logic              wr_done_valid,
  input logic              wr_done_ready
);
  logic wr_out, rd_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_out <= 1'b0;
      rd_out <= 1'b0;
    end else begin
      if (wr_req_valid && wr_req_ready)        wr_out <= 1'b1;
      else if (wr_done_valid && wr_done_ready) wr_out <= 1'b0;
      if (rd_req_valid && rd_req_ready)        rd_out <= 1'b1;
      else if (rd_resp_valid && rd_resp_ready) rd_out <= 1'b0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!out_valid && !rd_req_valid && !wr_req_valid && tok_ready));

  a_r8_hold_word: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_mark) && $stable(out_is_mark)));

  a_r9_one_write: assert property (@(posedge clk) disable iff (rst)
    wr_out |-> !wr_req_valid);

  a_r9_no_read_over_write: assert property (@(posedge clk) disable iff (rst)
    wr_out |-> !rd_req_valid);

  a_r7_busy_in_copy: assert property (@(posedge clk) disable iff (rst)
    rd_out |-> !tok_ready);

  a_r5_no_reserved_mark: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_mark) |-> !(out_mark >= 4'd3 && out_mark <= 4'd7));

  a_r5_mark_zero_data: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_mark) |-> (out_data == '0));
endmodule

bind lz_token_decoder lzd_checker #(.SYM_W(SYM_W), .MARK_W(lzd_pkg::MARK_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .tok_ready    (tok_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_is_mark  (out_is_mark),
  .out_data     (out_data),
  .out_mark     (out_mark),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_resp_valid(rd_resp_valid),
  .rd_resp_ready(rd_resp_ready),
  .wr_req_valid (wr_req_valid),
  .wr_req_ready (wr_req_ready),
  .wr_done_valid(wr_done_valid),
  .wr_done_ready(wr_done_ready)
);

// File: tb/lz_token_decoder_tb.sv
`timescale 1ns/1ps
module lz_token_decoder_tb_top;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NTOK  = 26;

  // token layout: {kind[45:44], sym[43:36], off[35:20], len[19:4], mark[3:0]}
  localparam logic [45:0] STIM [NTOK] = '{
    {2'd0, 8'h41, 16'd0,     16'd0, 4'd0},
    {2'd1, 8'h42, 16'd0,     16'd0, 4'd0},
    {2'd2, 8'h00, 16'd1,     16'd3, 4'd0},
    {2'd2, 8'h00, 16'd0,     16'd2, 4'd0},
    {2'd2, 8'h00, 16'd9,     16'd0, 4'd0},
    {2'd2, 8'h00, 16'd8,     16'd0, 4'd0},
    {2'd3, 8'h00, 16'd0,     16'd0, 4'd5},
    {2'd3, 8'h00, 16'd0,     16'd0, 4'd9},
    {2'd3, 8'h00, 16'd0,     16'd0, 4'd1},
    {2'd3, 8'h00, 16'd0,     16'd0, 4'd0},
    {2'd3, 8'h00, 16'd0,     16'd0, 4'hF},
    {2'd0, 8'h10, 16'd0,     16'd0, 4'd0},
    {2'd1, 8'h11, 16'd0,     16'd0, 4'd0},
    {2'd0, 8'h12, 16'd0,     16'd0, 4'd0},
    {2'd0, 8'h13, 16'd0,     16'd0, 4'd0},
    {2'd1, 8'h14, 16'd0,     16'd0, 4'd0},
    {2'd0, 8'h15, 16'd0,     16'd0, 4'd0},
    {2'd0, 8'h16, 16'd0,     16'd0, 4'd0},
    {2'd2, 8'h00, 16'd15,    16'd1, 4'd0},
    {2'd2, 8'h00, 16'd16,    16'd0, 4'd0},
    {2'd3, 8'h00, 16'd0,     16'd0, 4'd2},
    {2'd2, 8'h00, 16'd0,     16'd0, 4'd0},
    {2'd0, 8'h77, 16'd0,     16'd0, 4'd0},
    {2'd2, 8'h00, 16'd0,     16'd1, 4'd0},
    {2'd3, 8'h00, 16'd0,     16'd0, 4'd1},
    {2'd2, 8'h00, 16'd65535, 16'd2, 4'd0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        tok_valid = 1'b0;
  logic        tok_ready;
  logic [1:0]  tok_kind = '0;
  logic [7:0]  tok_sym = '0;
  logic [15:0] tok_off = '0;
  logic [15:0] tok_len = '0;
  logic [3:0]  tok_mark = '0;
  logic        out_valid, out_is_mark;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [3:0]  out_mark;
  logic        rd_req_valid, rd_resp_ready, wr_req_valid, wr_done_ready;
  logic        rd_req_ready = 1'b1;
  logic        wr_req_ready = 1'b1;
  logic        rd_resp_valid, wr_done_valid;
  logic [7:0]  rd_resp_data, wr_req_data;
  logic [AW-1:0] rd_req_addr, wr_req_addr;

  lz_token_decoder #(.SYM_W(8), .OFF_W(16), .LEN_W(16), .HIST_AW(AW)) dut_i (
    .clk(clk), .rst(rst),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_kind(tok_kind),
    .tok_sym(tok_sym), .tok_off(tok_off), .tok_len(tok_len), .tok_mark(tok_mark),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_mark(out_is_mark),
    .out_data(out_data), .out_mark(out_mark),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready), .rd_resp_data(rd_resp_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
    .wr_req_data(wr_req_data), .wr_done_valid(wr_done_valid), .wr_done_ready(wr_done_ready)
  );

  // history memory model with adjustable write-completion delay
  logic [7:0] mem [DEPTH];
  int  done_delay = 0;
  int  wcnt = 0;
  logic wpend = 1'b0;
  logic rv = 1'b0, dv = 1'b0;
  logic [7:0] rd_q = '0;
  assign rd_resp_valid = rv;
  assign rd_resp_data  = rd_q;
  assign wr_done_valid = dv;

  always @(posedge clk) begin
    if (rst) begin
      rv <= 1'b0; dv <= 1'b0; wpend <= 1'b0;
    end else begin
      if (rv && rd_resp_ready) rv <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        rv <= 1'b1; rd_q <= mem[rd_req_addr];
      end
      if (dv && wr_done_ready) dv <= 1'b0;
      if (wr_req_valid && wr_req_ready) begin
        mem[wr_req_addr] <= wr_req_data;
        wpend <= 1'b1; wcnt <= done_delay;
      end else if (wpend) begin
        if (wcnt == 0) begin dv <= 1'b1; wpend <= 1'b0; end
        else wcnt <= wcnt - 1;
      end
    end
  end

  // consumer: forced level or pseudo-random stalls
  logic bp_on = 1'b0;
  logic ready_force = 1'b1;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_on ? (lfsr[0] | lfsr[2]) : ready_force;
  end

  logic [12:0] cap_q [$];
  logic [12:0] exp_q [$];
  string       tag_q [$];

  always @(negedge clk)
    if (!rst && out_valid && out_ready) cap_q.push_back({out_is_mark, out_data, out_mark});

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input logic ok, input string req, input logic [12:0] act, input logic [12:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // reference model of the requirements
  logic [7:0] mh [DEPTH];
  int mptr = 0;
  int mcnt = 0;

  task automatic m_put(input logic [7:0] b);
    mh[mptr] = b;
    mptr = (mptr + 1) % DEPTH;
    if (mcnt < DEPTH) mcnt++;
  endtask

  task automatic model_token(input logic [45:0] t, input string tag);
    logic [1:0] k;
    int off, len;
    logic [3:0] m;
    string tg;
    k = t[45:44]; off = int'(t[35:20]); len = int'(t[19:4]); m = t[3:0];
    if (k == 2'd0 || k == 2'd1) begin
      exp_q.push_back({1'b0, t[43:36], 4'd0});
      tag_q.push_back(tag != "" ? tag : "R2");
      m_put(t[43:36]);
    end else if (k == 2'd2) begin
      if (off >= mcnt) begin
        exp_q.push_back({1'b1, 8'h00, 4'd9});
        tag_q.push_back(tag != "" ? tag : "R4");
      end else begin
        for (int i = 0; i <= len; i++) begin
          logic [7:0] b;
          b = mh[((mptr - off - 1) % DEPTH + DEPTH) % DEPTH];
          exp_q.push_back({1'b0, b, 4'd0});
          tag_q.push_back(tag != "" ? tag : "R3");
          m_put(b);
        end
      end
    end else begin
      tg = "R5";
      if (m == 4'd2) begin mptr = 0; mcnt = 0; tg = "R6"; end
      exp_q.push_back({1'b1, 8'h00, (m >= 4'd8 || m <= 4'd2) ? m : 4'd8});
      tag_q.push_back(tag != "" ? tag : tg);
    end
  endtask

  task automatic send(input logic [45:0] t, input string tag);
    model_token(t, tag);
    @(posedge clk); #2;
    tok_valid = 1'b1;
    {tok_kind, tok_sym, tok_off, tok_len, tok_mark} = t;
    do @(negedge clk); while (!tok_ready);
    @(posedge clk); #2;
    tok_valid = 1'b0;
  endtask

  task automatic drain_compare();
    int guard;
    guard = 0;
    while (cap_q.size() < exp_q.size() && guard < 4000) begin
      @(posedge clk); guard++;
    end
    repeat (6) @(posedge clk);
    chk(cap_q.size() == exp_q.size(), "R7 word count",
        13'(cap_q.size()), 13'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < cap_q.size(); i++)
      chk(cap_q[i] == exp_q[i], tag_q[i], cap_q[i], exp_q[i]);
    cap_q.delete(); exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(!out_valid, "R1 out_valid", 13'(out_valid), 13'd0);
    chk(tok_ready, "R1 tok_ready", 13'(tok_ready), 13'd1);
    chk(!rd_req_valid && !wr_req_valid, "R1 ram requests",
        13'({rd_req_valid, wr_req_valid}), 13'd0);

    // R8 / R7: stall the consumer
    ready_force = 1'b0;
    send({2'd0, 8'h5A, 16'd0, 16'd0, 4'd0}, "R8");
    repeat (6) @(negedge clk);
    chk(out_valid && !out_is_mark && out_data == 8'h5A, "R8 held word",
        {out_valid, out_data, out_mark}, {1'b1, 8'h5A, 4'd0});
    send({2'd2, 8'h00, 16'd0, 16'd3, 4'd0}, "R3");
    repeat (12) @(negedge clk);
    chk(out_data == 8'h5A && out_valid, "R8 still held",
        {out_valid, out_data, out_mark}, {1'b1, 8'h5A, 4'd0});
    chk(!tok_ready, "R7 busy during copy", 13'(tok_ready), 13'd0);
    ready_force = 1'b1;
    drain_compare();

    // R1: reset in the middle of a stream empties the history
    @(posedge clk); #2 rst = 1'b1;
    repeat (2) @(posedge clk); #2 rst = 1'b0;
    mptr = 0; mcnt = 0;
    send({2'd2, 8'h00, 16'd0, 16'd0, 4'd0}, "R1");
    drain_compare();

    // table of tokens under random backpressure
    bp_on = 1'b1;
    for (int i = 0; i < NTOK; i++) send(STIM[i], "");
    drain_compare();

    // R10 / R9: wrap and saturation with slow write completions
    bp_on = 1'b0; ready_force = 1'b1; done_delay = 3;
    send({2'd3, 8'h00, 16'd0, 16'd0, 4'd2}, "R6");
    for (int i = 0; i < DEPTH + 1; i++) send({2'd0, 8'(8'h80 + i), 16'd0, 16'd0, 4'd0}, "R9");
    send({2'd2, 8'h00, 16'(DEPTH - 1), 16'd0, 4'd0}, "R10");
    send({2'd2, 8'h00, 16'(DEPTH), 16'd0, 4'd0}, "R10");
    send({2'd2, 8'h00, 16'd0, 16'd4, 4'd0}, "R9");
    send({2'd3, 8'h00, 16'd0, 16'd0, 4'd1}, "R7");
    drain_compare();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule